// File: doc/BRIEF.md
# E1 Per-Timeslot Idle Code Inserter

This block sits on the transmit serial path of an E1 framer and rewrites chosen timeslots of the outgoing bit stream. A frame is 256 bit times, made of 32 eight-bit timeslots. For every timeslot, one bit of a 32-bit selection mask decides whether the slot is passed through or altered. In the normal mode, a selected slot carries a programmable 8-bit idle pattern, sent most significant bit first. In the alternate-source mode, the mask picks a source for each slot instead. A selected slot then carries the alternate serial input, which is taken from the receive side, and an unselected slot carries the primary transmit input.

Software programs the block through a simple write-only register bus. The selection mask is split across four byte-wide registers at consecutive addresses 0x26 to 0x29. The idle pattern is at 0x2A. The mode flag is bit 0 of 0x2B. A frame-sync pulse marks the first bit of timeslot 1. The block counts bit positions from that pulse and wraps on its own when a pulse is missing. Settings are taken at the first bit of each timeslot, so a slot never mixes old and new settings. The output is registered, and the sync pulse is delayed by the same single bit clock to stay aligned with the data.

Top module: `slot_sub_top`

## Requirements
- R1: While reset is low, and on the clock after it, txOut and syncOut are 0. All registers reset to zero, so the first frame after reset passes txIn through unchanged.
- R2: A frameSync high in a bit time makes that bit position 0, which is bit 7 of timeslot 1, at any point in the frame. Without frameSync, the position advances by one each clock and wraps from 255 to 0.
- R3: The byte written at address 0x26+k controls timeslots 8k+1 to 8k+8, for k = 0 to 3. Bit j of that byte controls timeslot 8k+j+1, so bit 0 of 0x26 controls timeslot 1 and bit 7 of 0x29 controls timeslot 32.
- R4: With the mode flag (bit 0 of 0x2B) at 0, a selected timeslot carries the byte written at 0x2A. Bit 7 is sent in the slot's first bit time and bit 0 in its last.
- R5: An unselected timeslot carries txIn unchanged, in either mode.
- R6: With the mode flag at 1, a selected timeslot carries altIn in place of txIn.
- R7: A write takes effect at the next timeslot boundary. The selection bit, the idle byte and the mode are sampled in the slot's first bit time and held for its remaining seven bits.
- R8: txOut shows the result for the serial inputs of the previous clock, and syncOut equals frameSync delayed by one clock.
- R9: Writes to any address outside 0x26 to 0x2B have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameSync | input | 1 | High in the first bit time of timeslot 1 |
| txIn | input | 1 | Primary transmit serial input |
| altIn | input | 1 | Alternate serial input from the receive side |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Register write address |
| busWdata | input | 8 | Register write data |
| txOut | output | 1 | Transmit serial output after substitution |
| syncOut | output | 1 | frameSync delayed to match txOut |

## Verification
Every serial result is due exactly one clock after its inputs are presented.

The bench drives a bit time on the falling edge and computes the expected bit from a position counter and register model of its own. It then waits for one rising edge and compares txOut and syncOut on the following falling edge.

A register write presented in a bit time reaches the shadow registers at that same rising edge. The write is visible in the output only from the first bit of a later timeslot. The model therefore samples its settings before applying the write, which checks that a write made in the middle of a slot stays invisible until that slot has finished.

// File: rtl/slot_sub_pkg.sv
package slot_sub_pkg;
  // Strobes passed from control to datapath for the current bit time
  typedef struct packed {
    logic pickIdle;  // send idle pattern bit
    logic pickAlt;   // send alternate serial input
    logic idleBit;   // idle pattern bit for this bit position
  } strobe_t;
endpackage

// File: rtl/slot_sub_ctrl.sv
module slot_sub_ctrl
  import slot_sub_pkg::*;
#(
  parameter int CH_COUNT  = 32,
  parameter int SLOT_BITS = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h26,
  localparam int POS_W = $clog2(CH_COUNT * SLOT_BITS),
  localparam int IDX_W = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SLOT_BITS-1:0] busWdata,
  output strobe_t           strb,
  output logic [POS_W-1:0]  posNow
);
  localparam int REG_COUNT = CH_COUNT / SLOT_BITS;
  localparam int CH_W = POS_W - IDX_W;
  localparam logic [ADDR_W-1:0] IDLE_ADDR = BASE_ADDR + ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] MODE_ADDR = IDLE_ADDR + ADDR_W'(1);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SLOT_BITS - 1);

  logic [POS_W-1:0]     cnt;
  logic [CH_W-1:0]      chanIdx;
  logic [IDX_W-1:0]     bitIdx;
  logic [SLOT_BITS-1:0] selReg [REG_COUNT];
  logic [CH_COUNT-1:0]  selFlat;
  logic [SLOT_BITS-1:0] idleReg;
  logic                 modeReg;
  // settings held for the remainder of the current slot
  logic                 heldSel, heldMode;
  logic [SLOT_BITS-1:0] heldIdle;
  logic                 curSel, curMode;
  logic [SLOT_BITS-1:0] curIdle;
  logic                 slotStart;

  // Bit position: sync forces position zero in this bit time
  assign posNow  = frameSync ? '0 : cnt;
  assign chanIdx = posNow[POS_W-1:IDX_W];
  assign bitIdx  = posNow[IDX_W-1:0];
  assign slotStart = (bitIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= posNow + POS_W'(1);
  end

  // Channel-select shadow registers, one per byte of the mask
  for (genvar k = 0; k < REG_COUNT; k++) begin : g_selReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selReg[k] <= '0;
      else if (busWe && busAddr == BASE_ADDR + ADDR_W'(k)) selReg[k] <= busWdata;
    end
    assign selFlat[k*SLOT_BITS +: SLOT_BITS] = selReg[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleReg <= '0;
      modeReg <= 1'b0;
    end else if (busWe) begin
      if (busAddr == IDLE_ADDR) idleReg <= busWdata;
      if (busAddr == MODE_ADDR) modeReg <= busWdata[0];
    end
  end

  // Settings sampled at slot start, held until the next slot
  always_comb begin
    curSel  = slotStart ? selFlat[chanIdx] : heldSel;
    curMode = slotStart ? modeReg          : heldMode;
    curIdle = slotStart ? idleReg          : heldIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSel  <= 1'b0;
      heldMode <= 1'b0;
      heldIdle <= '0;
    end else begin
      heldSel  <= curSel;
      heldMode <= curMode;
      heldIdle <= curIdle;
    end
  end

  always_comb begin
    strb.pickIdle = curSel & ~curMode;
    strb.pickAlt  = curSel & curMode;
    strb.idleBit  = curIdle[TOP_IDX - bitIdx];
  end
endmodule

// File: rtl/slot_sub_dp.sv
module slot_sub_dp
  import slot_sub_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    txIn,
  input  logic    altIn,
  input  logic    frameSync,
  output logic    txOut,
  output logic    syncOut
);
  logic nextBit;

  always_comb begin
    if (strb.pickIdle)     nextBit = strb.idleBit;
    else if (strb.pickAlt) nextBit = altIn;
    else                   nextBit = txIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOut   <= 1'b0;
      syncOut <= 1'b0;
    end else begin
      txOut   <= nextBit;
      syncOut <= frameSync;
    end
  end
endmodule

// File: rtl/slot_sub_top.sv
module slot_sub_top
  import slot_sub_pkg::*;
#(
  parameter int CH_COUNT  = 32,
  parameter int SLOT_BITS = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h26
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameSync,
  input  logic                 txIn,
  input  logic                 altIn,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [SLOT_BITS-1:0] busWdata,
  output logic                 txOut,
  output logic                 syncOut
);
  localparam int POS_W = $clog2(CH_COUNT * SLOT_BITS);

  strobe_t          strb;
  logic [POS_W-1:0] posNow;

  slot_sub_ctrl #(
    .CH_COUNT(CH_COUNT), .SLOT_BITS(SLOT_BITS),
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .strb(strb), .posNow(posNow)
  );

  slot_sub_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txIn(txIn), .altIn(altIn), .frameSync(frameSync),
    .txOut(txOut), .syncOut(syncOut)
  );
endmodule

// File: rtl/slot_sub_check.sv
module slot_sub_check
  import slot_sub_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameSync,
  input logic             txIn,
  input logic             altIn,
  input logic             txOut,
  input logic             syncOut,
  input strobe_t          strb,
  input logic [POS_W-1:0] posNow
);
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (txOut == 1'b0 && syncOut == 1'b0);
    end
  end

  p_sync_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (frameSync || posNow == POS_W'(1)));

  p_idle_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.pickIdle |=> txOut == $past(strb.idleBit));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pickIdle && !strb.pickAlt) |=> txOut == $past(txIn));

  p_alt_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pickAlt |=> txOut == $past(altIn));

  p_one_choice_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pickIdle, strb.pickAlt}));

  p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (posNow[IDX_W-1:0] != '0) |-> $stable({strb.pickIdle, strb.pickAlt}));

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> syncOut);
endmodule

bind slot_sub_top slot_sub_check #(.POS_W(POS_W), .IDX_W($clog2(SLOT_BITS))) u_check (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .txIn(txIn), .altIn(altIn),
  .txOut(txOut), .syncOut(syncOut), .strb(strb), .posNow(posNow)
);

// File: tb/slot_sub_top_test.sv
`timescale 1ns/1ps
module slot_sub_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSync = 1'b0, txIn = 1'b0, altIn = 1'b0, busWe = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic       txOut, syncOut;

  int checks = 0;
  int errors = 0;

  // bench model of the requirements
  int         mCnt = 0;
  bit [31:0]  mSel = '0;
  bit [7:0]   mIdle = '0;
  bit         mMode = 1'b0;
  bit         lSel = 1'b0, lMode = 1'b0;
  bit [7:0]   lIdle = '0;

  always #2 clk = ~clk;

  slot_sub_top uut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .txIn(txIn), .altIn(altIn),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .txOut(txOut), .syncOut(syncOut)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // Model register write (R3, R9 decode)
  function automatic void modelWrite(input bit [7:0] a, input bit [7:0] d);
    if (a >= 8'h26 && a <= 8'h29) mSel[(a - 8'h26) * 8 +: 8] = d;
    else if (a == 8'h2A) mIdle = d;
    else if (a == 8'h2B) mMode = d[0];
  endfunction

  // One bit time: drive at negedge, compare one clock later
  task automatic cycle(input bit fs, input bit tin, input bit ain,
                       input bit we, input bit [7:0] a, input bit [7:0] d,
                       input string tag);
    int pos, ch, bi;
    bit exp;
    string t;
    frameSync = fs; txIn = tin; altIn = ain;
    busWe = we; busAddr = a; busWdata = d;
    pos = fs ? 0 : mCnt;
    ch = pos / 8;
    bi = pos % 8;
    if (bi == 0) begin
      lSel = mSel[ch]; lMode = mMode; lIdle = mIdle;
    end
    exp = lSel ? (lMode ? ain : lIdle[7 - bi]) : tin;
    if (tag != "") t = tag;
    else t = lSel ? (lMode ? "R6" : "R4") : "R5";
    @(posedge clk);
    mCnt = (pos + 1) % 256;
    if (we) modelWrite(a, d);
    @(negedge clk);
    check(txOut, exp, t);
    check(syncOut, fs, "R8");
  endtask

  task automatic idleBits(input int n, input string tag);
    for (int i = 0; i < n; i++)
      cycle(1'b0, 1'($urandom), 1'($urandom), 1'b0, 8'h00, 8'h00, tag);
  endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    cycle(1'b0, 1'($urandom), 1'($urandom), 1'b1, a, d, "");
  endtask

  task automatic frame(input string tag);
    cycle(1'b1, 1'($urandom), 1'($urandom), 1'b0, 8'h00, 8'h00, tag);
    idleBits(255, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (2) @(negedge clk);
    check(txOut, 1'b0, "R1");
    check(syncOut, 1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    check(txOut, 1'b0, "R1");
    // R1: first frame after reset passes txIn
    frame("R1");

    // R3/R4: idle pattern in timeslots 1 and 32
    wr(8'h2A, 8'hA5);
    wr(8'h26, 8'h01);
    wr(8'h29, 8'h80);
    frame("R3");
    frame("");

    // R4/R5: a different mask and pattern
    wr(8'h27, 8'h5A);
    wr(8'h28, 8'hC3);
    wr(8'h2A, 8'h3C);
    frame("");

    // R6: alternate-source mode
    wr(8'h2B, 8'h01);
    frame("R6");
    frame("");
    wr(8'h2B, 8'h00);

    // R7: write to timeslot 6 control in the middle of that slot
    wr(8'h26, 8'h00);
    wr(8'h2A, 8'hFF);
    cycle(1'b1, 1'($urandom), 1'($urandom), 1'b0, 8'h00, 8'h00, "R7");
    while (mCnt != 5 * 8 + 3) idleBits(1, "R7");
    cycle(1'b0, 1'($urandom), 1'($urandom), 1'b1, 8'h26, 8'h20, "R7");
    idleBits(300, "R7");

    // R9: writes to unmapped addresses are ignored
    for (int k = 0; k < 4; k++) wr(8'h26 + 8'(k), 8'h00);
    cycle(1'b0, 1'($urandom), 1'($urandom), 1'b1, 8'h25, 8'hFF, "R9");
    cycle(1'b0, 1'($urandom), 1'($urandom), 1'b1, 8'h2C, 8'hFF, "R9");
    cycle(1'b0, 1'($urandom), 1'($urandom), 1'b1, 8'h06, 8'hFF, "R9");
    frame("R9");

    // R2: free-running wrap, then a realigning sync in mid-frame
    wr(8'h26, 8'h81);
    wr(8'h28, 8'h18);
    wr(8'h2A, 8'h96);
    idleBits(600, "R2");
    cycle(1'b1, 1'($urandom), 1'($urandom), 1'b0, 8'h00, 8'h00, "R2");
    idleBits(100, "R2");
    cycle(1'b1, 1'($urandom), 1'($urandom), 1'b0, 8'h00, 8'h00, "R2");
    idleBits(260, "R2");

    // Constrained random mix of all requirements
    for (int i = 0; i < 4000; i++) begin
      bit fs, we;
      bit [7:0] a;
      fs = (mCnt == 0 && ($urandom % 4) != 0) || ($urandom % 400 == 0);
      we = ($urandom % 30 == 0);
      a  = 8'h24 + 8'($urandom % 10);
      cycle(fs, 1'($urandom), 1'($urandom), we, a, 8'($urandom), "");
    end

    summary();
    $finish;
  end
endmodule